// File: doc/BRIEF.md
# Predict-Taken Branch Squash Controller

This block tracks instructions through the front end of a ten-stage in-order pipeline and decides where fetch goes next. Every conditional branch and every unconditional jump is treated as taken as soon as it is fetched, so the fetch address moves straight to the target supplied with the instruction. Conditional branches learn their real outcome in stage 7. A branch that turns out taken costs nothing.

A branch that turns out not taken is a misprediction. In that cycle the controller raises a redirect that carries the fall-through address (branch PC plus 4). It also raises one squash flag for each valid younger instruction in stages 1 to 6. At the next clock edge those stages become empty and fetch resumes at the fall-through address. Each misprediction adds six cycles to a running penalty total. Counters of resolved and not-taken branches are kept next to that total.

Stage 1 is the fetch slot itself, and it reads the fetch inputs in the cycle they are driven. Stages 2 to 10 are registers that carry a valid bit, a conditional-branch bit and the PC.

Top module: `pt_branch_squash`

## Requirements
- R1: After reset, `fetch_pc` equals the `RESET_VEC` parameter, all registered stage valid bits (`stage_valid[9:1]`) are 0, and all three counters are 0.
- R2: Fetch of a valid instruction with `if_is_cbr` or `if_is_jmp` set makes the next `fetch_pc` equal to `if_target`. Any other valid fetch advances `fetch_pc` by 4. When `if_valid` is low, `fetch_pc` holds.
- R3: Each instruction moves one stage per cycle. `stage_valid` bit i-1 reports stage i, and bit 0 reports the fetch slot (`if_valid`).
- R4: A valid conditional branch in stage 7 with `res_taken`=1 raises neither `redirect` nor any `squash` bit, and leaves `penalty_cycles` unchanged. `br_count` rises by 1.
- R5: A valid conditional branch in stage 7 with `res_taken`=0 raises `redirect` in that cycle, with `redirect_pc` equal to the branch PC plus 4. `squash` bit i-1 is set exactly for the valid stages i among stages 1 to 6.
- R6: In the cycle after a not-taken resolution, `fetch_pc` equals the fall-through address and stages 2 to 7 are empty. The branch itself is valid in stage 8.
- R7: Each not-taken resolution adds 6 to `penalty_cycles` and 1 to `nt_count`, in addition to the 1 it adds to `br_count`.
- R8: An unconditional jump that reaches stage 7 never raises `redirect`, whatever `res_taken` is, and changes no counter.
- R9: A conditional branch removed by a squash never resolves. It raises no redirect and changes no counter in the cycle where it would have reached stage 7.
- R10: When a not-taken resolution and the fetch of a branch or jump fall in the same cycle, the redirect wins: the next `fetch_pc` is the fall-through address, not `if_target`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Instruction present in the fetch slot this cycle |
| if_is_cbr | input | 1 | Fetched instruction is a conditional branch |
| if_is_jmp | input | 1 | Fetched instruction is an unconditional jump |
| if_target | input | AW | Target of the fetched branch or jump |
| res_taken | input | 1 | Actual outcome of the stage-7 branch (1 = taken) |
| fetch_pc | output | AW | Address fetched this cycle |
| redirect | output | 1 | Fetch redirect request after a mispredicted branch |
| redirect_pc | output | AW | Fall-through address for the redirect |
| squash | output | 6 | Kill flags for stages 1 to 6 (bit i-1 = stage i) |
| stage_valid | output | STAGES | Valid bit of each stage (bit i-1 = stage i) |
| br_count | output | CW | Resolved conditional branches |
| nt_count | output | CW | Not-taken resolutions |
| penalty_cycles | output | CW | Accumulated misprediction penalty in cycles |

## Verification
Two fetch-address decisions can fall in the same cycle. A not-taken branch can resolve in stage 7 while the fetch slot holds a new branch that would send fetch to its own target. The bench provokes this by feeding a branch fetch in exactly the resolving cycle. It then requires the next fetch address to be the fall-through of the older branch, and it requires the new branch to disappear from the stage valid bits. A second overlap puts a mispredicting branch and a younger conditional branch in flight together. The bench then requires that the younger branch leaves the counters untouched one cycle later.

// File: rtl/pt_branch_squash.sv
module pt_branch_squash #(
  parameter int AW = 32,
  parameter int STAGES = 10,
  parameter int RES_STAGE = 7,
  parameter int CW = 16,
  parameter int ISZ = 4,
  parameter logic [AW-1:0] RESET_VEC = 'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_valid,
  input  logic              if_is_cbr,
  input  logic              if_is_jmp,
  input  logic [AW-1:0]     if_target,
  input  logic              res_taken,
  output logic [AW-1:0]     fetch_pc,
  output logic              redirect,
  output logic [AW-1:0]     redirect_pc,
  output logic [RES_STAGE-2:0] squash,
  output logic [STAGES-1:0] stage_valid,
  output logic [CW-1:0]     br_count,
  output logic [CW-1:0]     nt_count,
  output logic [CW-1:0]     penalty_cycles
);
  localparam int NSQ = RES_STAGE - 1;
  localparam int PEN = NSQ;

  logic          p_v   [STAGES:2];
  logic          p_cbr [STAGES:2];
  logic [AW-1:0] p_pc  [STAGES:2];

  logic resolve;
  assign resolve     = p_v[RES_STAGE] && p_cbr[RES_STAGE];
  assign redirect    = resolve && !res_taken;
  assign redirect_pc = p_pc[RES_STAGE] + AW'(ISZ);
  assign squash      = {NSQ{redirect}} & stage_valid[NSQ-1:0];

  assign stage_valid[0] = if_valid;
  for (genvar k = 2; k <= STAGES; k++) begin : g_vout
    assign stage_valid[k-1] = p_v[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v[2]   <= 1'b0;
      p_cbr[2] <= 1'b0;
      p_pc[2]  <= '0;
    end else begin
      p_v[2]   <= if_valid && !redirect;
      p_cbr[2] <= if_valid && if_is_cbr;
      p_pc[2]  <= fetch_pc;
    end
  end

  for (genvar k = 3; k <= STAGES; k++) begin : g_stage
    localparam bit KILLABLE = (k - 1) <= NSQ;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_v[k]   <= 1'b0;
        p_cbr[k] <= 1'b0;
        p_pc[k]  <= '0;
      end else begin
        p_v[k]   <= p_v[k-1] && !(KILLABLE && redirect);
        p_cbr[k] <= p_cbr[k-1];
        p_pc[k]  <= p_pc[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      fetch_pc <= RESET_VEC;
    else if (redirect)
      fetch_pc <= redirect_pc;
    else if (if_valid && (if_is_cbr || if_is_jmp))
      fetch_pc <= if_target;
    else if (if_valid)
      fetch_pc <= fetch_pc + AW'(ISZ);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_count       <= '0;
      nt_count       <= '0;
      penalty_cycles <= '0;
    end else if (resolve) begin
      br_count <= br_count + 1'b1;
      if (!res_taken) begin
        nt_count       <= nt_count + 1'b1;
        penalty_cycles <= penalty_cycles + CW'(PEN);
      end
    end
  end

  p_pred_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (if_valid && (if_is_cbr || if_is_jmp) && !redirect) |=> fetch_pc == $past(if_target));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_valid && !redirect) |=> $stable(fetch_pc));
  p_taken_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && res_taken) |=> $stable(penalty_cycles));
  p_refetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_pc == $past(redirect_pc));
  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (stage_valid[RES_STAGE-1:1] == '0) && stage_valid[RES_STAGE]);
  p_penalty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> penalty_cycles == $past(penalty_cycles) + CW'(PEN));
  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);
endmodule

// File: tb/tb_pt_branch_squash.sv
module tb_pt_branch_squash;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_valid = 1'b0, if_is_cbr = 1'b0, if_is_jmp = 1'b0, res_taken = 1'b1;
  logic [31:0] if_target = '0;
  logic [31:0] fetch_pc, redirect_pc;
  logic redirect;
  logic [5:0] squash;
  logic [9:0] stage_valid;
  logic [15:0] br_count, nt_count, penalty_cycles;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] pc_e;
  int br_e = 0, nt_e = 0, pen_e = 0;

  always #2 clk = ~clk;

  pt_branch_squash dut (
    .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_is_cbr(if_is_cbr),
    .if_is_jmp(if_is_jmp), .if_target(if_target), .res_taken(res_taken),
    .fetch_pc(fetch_pc), .redirect(redirect), .redirect_pc(redirect_pc),
    .squash(squash), .stage_valid(stage_valid), .br_count(br_count),
    .nt_count(nt_count), .penalty_cycles(penalty_cycles)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit cbr, input bit jmp, input logic [31:0] tgt, input bit rt);
    @(negedge clk);
    if_valid = v; if_is_cbr = cbr; if_is_jmp = jmp; if_target = tgt; res_taken = rt;
    #1;
    chk(fetch_pc == pc_e, "R2 fetch_pc", fetch_pc, pc_e);
    if (v) pc_e = (cbr || jmp) ? tgt : pc_e + 32'd4;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 1);
  endtask

  task automatic chk_counts(input string tag);
    chk(br_count == 16'(br_e), {tag, " br_count"}, 32'(br_count), 32'(br_e));
    chk(nt_count == 16'(nt_e), {tag, " nt_count"}, 32'(nt_count), 32'(nt_e));
    chk(penalty_cycles == 16'(pen_e), {tag, " penalty"}, 32'(penalty_cycles), 32'(pen_e));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    pc_e = 32'h1000;
    #1;
    chk(fetch_pc == 32'h1000, "R1 reset pc", fetch_pc, 32'h1000);
    chk(stage_valid[9:1] == '0, "R1 stages empty", 32'(stage_valid), 0);
    chk_counts("R1");
  endtask

  task automatic t_seq;
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    chk(stage_valid[3:0] == 4'b1101, "R3 stage flow", 32'(stage_valid[3:0]), 32'hD);
  endtask

  task automatic t_taken;
    step(1, 1, 0, 32'h2000, 1);
    fill(5);
    step(1, 0, 0, 0, 1);
    chk(redirect == 1'b0, "R4 no redirect", 32'(redirect), 0);
    chk(squash == 6'h00, "R4 no squash", 32'(squash), 0);
    br_e++;
    step(1, 0, 0, 0, 1);
    chk_counts("R4");
  endtask

  task automatic t_nottaken;
    logic [31:0] bpc;
    bpc = pc_e;
    step(1, 1, 0, 32'h3000, 1);
    fill(5);
    step(1, 1, 0, 32'h4000, 0);
    chk(redirect == 1'b1, "R5 redirect", 32'(redirect), 1);
    chk(redirect_pc == bpc + 32'd4, "R5 redirect_pc", redirect_pc, bpc + 32'd4);
    chk(squash == 6'h3F, "R5 squash all", 32'(squash), 32'h3F);
    pc_e = bpc + 32'd4;
    br_e++; nt_e++; pen_e += 6;
    step(1, 0, 0, 0, 1);
    chk(fetch_pc == bpc + 32'd4, "R10 redirect wins", fetch_pc, bpc + 32'd4);
    chk(stage_valid[6:1] == '0, "R6 stages 2-7 empty", 32'(stage_valid[6:1]), 0);
    chk(stage_valid[7] == 1'b1, "R6 branch in stage 8", 32'(stage_valid[7]), 1);
    chk_counts("R7");
  endtask

  task automatic t_jump;
    step(1, 0, 1, 32'h5000, 1);
    fill(5);
    step(1, 0, 0, 0, 0);
    chk(redirect == 1'b0, "R8 jump no redirect", 32'(redirect), 0);
    step(1, 0, 0, 0, 1);
    chk_counts("R8");
  endtask

  task automatic t_squashed;
    logic [31:0] apc;
    apc = pc_e;
    step(1, 1, 0, 32'h6000, 1);
    step(1, 1, 0, 32'h7000, 1);
    fill(4);
    step(1, 0, 0, 0, 0);
    chk(redirect == 1'b1, "R5 older redirect", 32'(redirect), 1);
    chk(redirect_pc == apc + 32'd4, "R5 older redirect_pc", redirect_pc, apc + 32'd4);
    pc_e = apc + 32'd4;
    br_e++; nt_e++; pen_e += 6;
    step(1, 0, 0, 0, 0);
    chk(redirect == 1'b0, "R9 squashed branch silent", 32'(redirect), 0);
    step(1, 0, 0, 0, 1);
    chk_counts("R9");
  endtask

  task automatic t_bubble;
    logic [31:0] cpc;
    cpc = pc_e;
    step(1, 1, 0, 32'h8000, 1);
    step(0, 0, 0, 0, 1);
    fill(4);
    step(1, 0, 0, 0, 0);
    chk(squash == 6'b011111, "R5 squash valid only", 32'(squash), 32'h1F);
    chk(redirect_pc == cpc + 32'd4, "R5 bubble redirect_pc", redirect_pc, cpc + 32'd4);
    pc_e = cpc + 32'd4;
    br_e++; nt_e++; pen_e += 6;
    step(1, 0, 0, 0, 1);
    chk_counts("R7 second");
  endtask

  initial begin
    t_reset();
    t_seq();
    t_taken();
    t_nottaken();
    t_jump();
    t_squashed();
    t_bubble();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule